// File: doc/BRIEF.md
# Single-Carrier Five-Level Gate Modulator

This block turns a signed reference sample into gate commands for a five-level converter stage. The stage has an H-bridge whose legs only set the output polarity, and two fast DC-link legs that choose between full, half and zero magnitude. A single internal triangular carrier, counting from 0 up to `CAR_PEAK` and back down, is compared against one value taken from the reference magnitude. That one comparison drives all four level decisions. When the magnitude exceeds `CAR_PEAK` the stage works in a full band, switching between full and half level. Otherwise it works in a half band, switching between half and zero.

The half-level state can be built with either DC-link switch. The block rotates between them on every half-level interval so that the two DC-link capacitors share the load. Each of the four legs has a high and a low gate. Every leg passes through its own dead-time stage, so both gates are off for `dead_i + 1` cycles whenever its command changes. The DC-link gates are also held off for as long as the H-bridge is reversing polarity. A signed level output reports the level the block intends to apply.

Top module: `pwm5_mod`

## Requirements
- R1: The reference is taken in only on cycles where the carrier sits at 0 or at `CAR_PEAK`. A change of `ref_i` at any other time has no effect on the outputs until the next such cycle.
- R2: While the held reference is greater than zero, H-bridge leg A drives its high gate (`gate_o[0]`) and leg B drives its low gate (`gate_o[3]`). While it is zero or negative, `gate_o[1]` and `gate_o[2]` are driven instead. `gate_o[0]` and `gate_o[2]` are never on together, and neither are `gate_o[1]` and `gate_o[3]`.
- R3: For each leg k (0 = H-bridge A, 1 = H-bridge B, 2 = upper DC-link switch, 3 = lower DC-link switch), the high gate `gate_o[2k]` and the low gate `gate_o[2k+1]` are never on in the same cycle.
- R4: Full band: when |ref| > `CAR_PEAK`, the level magnitude is 2 in cycles where |ref| − `CAR_PEAK` > carrier, and 1 otherwise.
- R5: Half band: when |ref| ≤ `CAR_PEAK` (this includes a reference of zero), the level magnitude is 1 in cycles where |ref| > carrier, and 0 otherwise.
- R6: Level magnitude 2 turns on both DC-link main gates (`gate_o[4]`, `gate_o[6]`). Magnitude 0 turns on neither. Magnitude 1 turns on exactly one of them, and the choice alternates on each successive half-level interval. The first interval after reset uses `gate_o[4]`.
- R7: `level_o` is a 3-bit two's-complement value in the range −2 to +2. It carries the sign of the held reference and appears one clock after the carrier value it was decided on.
- R8: When a leg's command changes, both of its gates are off for exactly `dead_i + 1` cycles before the new gate turns on.
- R9: A DC-link gate (`gate_o[7:4]`) is on only in cycles where exactly one gate of H-bridge leg A is on.
- R10: While `rst_n_i` is low, all gates are off and `level_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock; the carrier moves one step per cycle |
| rst_n_i | input | 1 | Active-low synchronous reset |
| ref_i | input | REF_W | Signed reference sample |
| dead_i | input | DT_W | Dead time in clock cycles, added to a fixed one-cycle gap |
| gate_o | output | 8 | Gate commands: [1:0] leg A high/low, [3:2] leg B high/low, [5:4] upper DC-link complement/main, [7:6] lower DC-link complement/main; within each leg the even bit is high and the odd bit is low |
| level_o | output | 3 | Signed intended output level, −2 to +2 |

## Verification
The assertions check the safety relations on every cycle: no leg shorts, the high gates of the two H-bridge legs are never on together, no gate turns on straight after its partner, and DC-link gates conduct only while the H-bridge leg is settled. They also check that the held reference moves only at carrier turning points, that a full-level command shows up as a level of ±2, and that the level code stays in range. The bench's scenarios are needed for the rest: the exact level decided in each band against the carrier, the rotation of the half-level switch over successive intervals, and the measured length of the dead-time gap at a polarity reversal.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

  // magnitude of the DC-link contribution
  typedef enum logic [1:0] {
    LV_ZERO = 2'd0,
    LV_HALF = 2'd1,
    LV_FULL = 2'd2
  } lv_mag_e;

  // absolute value of a sign-extended reference
  function automatic int ref_mag(input int r);
    return (r < 0) ? -r : r;
  endfunction

  // value that meets the carrier in the active band
  function automatic int band_cmp(input int mag, input int peak);
    return (mag > peak) ? (mag - peak) : mag;
  endfunction

  // pick the level magnitude for one carrier sample
  function automatic lv_mag_e pick_level(input int mag, input int peak, input int car);
    logic above;
    above = band_cmp(mag, peak) > car;
    if (mag > peak) return above ? LV_FULL : LV_HALF;
    return above ? LV_HALF : LV_ZERO;
  endfunction

  // signed code of the level reported to the outside
  function automatic logic signed [2:0] signed_level(input lv_mag_e m, input logic pos);
    logic signed [2:0] v;
    case (m)
      LV_FULL: v = 3'sd2;
      LV_HALF: v = 3'sd1;
      default: v = 3'sd0;
    endcase
    return pos ? v : -v;
  endfunction

endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier #(
  parameter int PEAK  = 100,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             turn_o
);

  logic rising_q;

  // turning point: valley or peak of the triangle
  assign turn_o = (cnt_o == '0) || (cnt_o == CNT_W'(PEAK));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cnt_o    <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      cnt_o <= cnt_o + 1'b1;
      if (cnt_o == CNT_W'(PEAK - 1)) rising_q <= 1'b0;
    end else begin
      cnt_o <= cnt_o - 1'b1;
      if (cnt_o == CNT_W'(1)) rising_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pwm5_decide.sv
module pwm5_decide
  import pwm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int PEAK  = 100,
  parameter int CNT_W = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    turn_i,
  output logic signed [REF_W-1:0] ref_q_o,
  output logic                    pos_o,
  output lv_mag_e                 lvl_o
);

  int mag;

  // reference held constant between turning points
  always_ff @(posedge clk_i) begin
    if (!rst_n_i)    ref_q_o <= '0;
    else if (turn_i) ref_q_o <= ref_i;
  end

  assign pos_o = !ref_q_o[REF_W-1] && (ref_q_o != '0);

  always_comb begin
    mag   = ref_mag(int'(ref_q_o));
    lvl_o = pick_level(mag, PEAK, int'(cnt_i));
  end

endmodule

// File: rtl/pwm5_balance.sv
module pwm5_balance
  import pwm5_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_n_i,
  input  lv_mag_e                lvl_i,
  input  logic                   pos_i,
  output logic                   up_cmd_o,
  output logic                   dn_cmd_o,
  output logic                   half_end_o,
  output logic signed [2:0]      level_o
);

  logic half_now;
  logic full_now;
  logic half_q;
  logic pick_dn_q;

  assign half_now   = (lvl_i == LV_HALF);
  assign full_now   = (lvl_i == LV_FULL);
  assign half_end_o = half_q && !half_now;

  // half level goes to one switch, full level to both
  assign up_cmd_o = full_now || (half_now && !pick_dn_q);
  assign dn_cmd_o = full_now || (half_now && pick_dn_q);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      half_q    <= 1'b0;
      pick_dn_q <= 1'b0;
      level_o   <= 3'sd0;
    end else begin
      half_q  <= half_now;
      level_o <= signed_level(lvl_i, pos_i);
      if (half_end_o) pick_dn_q <= !pick_dn_q;
    end
  end

endmodule

// File: rtl/pwm5_leg.sv
module pwm5_leg #(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            cmd_i,
  input  logic [DT_W-1:0] dead_i,
  input  logic            hold_i,
  output logic            hi_o,
  output logic            lo_o,
  output logic            busy_o
);

  logic            cur_q;
  logic [DT_W-1:0] left_q;

  // leg is in a blanking gap this cycle
  assign busy_o = (cmd_i != cur_q) || (left_q != '0);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cur_q  <= 1'b0;
      left_q <= '0;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else if (cmd_i != cur_q) begin
      cur_q  <= cmd_i;
      left_q <= dead_i;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else begin
      hi_o <= cur_q && !hold_i;
      lo_o <= !cur_q && !hold_i;
    end
  end

endmodule

// File: rtl/pwm5_mod.sv
module pwm5_mod
  import pwm5_pkg::*;
#(
  parameter int REF_W    = 12,
  parameter int CAR_PEAK = 100,
  parameter int DT_W     = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [7:0]              gate_o,
  output logic signed [2:0]       level_o
);

  localparam int CNT_W = $clog2(CAR_PEAK + 1);
  localparam int NLEG  = 4;

  logic [CNT_W-1:0]        car_cnt;
  logic                    car_turn;
  logic signed [REF_W-1:0] ref_held;
  logic                    ref_pos;
  lv_mag_e                 lvl_pick;
  logic                    up_cmd;
  logic                    dn_cmd;
  logic                    half_end;
  logic                    hb_busy;
  logic [NLEG-1:0]         leg_cmd;
  logic [NLEG-1:0]         leg_hold;
  logic [NLEG-1:0]         leg_busy;
  logic [NLEG-1:0]         leg_hi;
  logic [NLEG-1:0]         leg_lo;

  pwm5_carrier #(.PEAK(CAR_PEAK), .CNT_W(CNT_W)) u_car (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .cnt_o   (car_cnt),
    .turn_o  (car_turn)
  );

  pwm5_decide #(.REF_W(REF_W), .PEAK(CAR_PEAK), .CNT_W(CNT_W)) u_dec (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .ref_i   (ref_i),
    .cnt_i   (car_cnt),
    .turn_i  (car_turn),
    .ref_q_o (ref_held),
    .pos_o   (ref_pos),
    .lvl_o   (lvl_pick)
  );

  pwm5_balance u_bal (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .lvl_i      (lvl_pick),
    .pos_i      (ref_pos),
    .up_cmd_o   (up_cmd),
    .dn_cmd_o   (dn_cmd),
    .half_end_o (half_end),
    .level_o    (level_o)
  );

  // leg 0/1: H-bridge polarity, leg 2/3: DC-link level switches
  assign leg_cmd = {dn_cmd, up_cmd, !ref_pos, ref_pos};
  assign hb_busy = leg_busy[0];

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    if (k < 2) begin : g_hb
      assign leg_hold[k] = 1'b0;
    end else begin : g_dc
      assign leg_hold[k] = hb_busy;
    end

    pwm5_leg #(.DT_W(DT_W)) u_leg (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .cmd_i   (leg_cmd[k]),
      .dead_i  (dead_i),
      .hold_i  (leg_hold[k]),
      .hi_o    (leg_hi[k]),
      .lo_o    (leg_lo[k]),
      .busy_o  (leg_busy[k])
    );

    assign gate_o[2*k]   = leg_hi[k];
    assign gate_o[2*k+1] = leg_lo[k];
  end

endmodule

// File: rtl/pwm5_mod_chk.sv
module pwm5_mod_chk #(
  parameter int RW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           gate,
  input logic signed [2:0]    level,
  input logic                 turn,
  input logic signed [RW-1:0] ref_q,
  input logic                 up_cmd,
  input logic                 dn_cmd
);

  for (genvar k = 0; k < 4; k++) begin : g_leg
    // R3
    leg_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[2*k] && gate[2*k+1]));
    // R8
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[2*k+1]) |-> !$past(gate[2*k]));
    // R8
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[2*k]) |-> !$past(gate[2*k+1]));
  end

  // R2
  bridge_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[2]) && !(gate[1] && gate[3]));

  // R9
  dc_during_reversal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate[7:4]) |-> (gate[0] ^ gate[1]));

  // R1
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !turn |=> $stable(ref_q));

  // R4
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cmd && dn_cmd) |=> (level == 3'sd2 || level == -3'sd2));

  // R7
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= -3'sd2) && (level <= 3'sd2));

endmodule

bind pwm5_mod pwm5_mod_chk #(.RW(REF_W)) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_n_i),
  .gate   (gate_o),
  .level  (level_o),
  .turn   (car_turn),
  .ref_q  (ref_held),
  .up_cmd (up_cmd),
  .dn_cmd (dn_cmd)
);

// File: tb/pwm5_mod_tb_top.sv
module pwm5_mod_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 12;
  localparam int P  = 16;
  localparam int DW = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [RW-1:0] ref_r = '0;
  logic [DW-1:0]        dead_r = '0;
  logic [7:0]           gate;
  logic signed [2:0]    level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm5_mod #(.REF_W(RW), .CAR_PEAK(P), .DT_W(DW)) dut_i (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .ref_i   (ref_r),
    .dead_i  (dead_r),
    .gate_o  (gate),
    .level_o (level)
  );

  // ---------------- reference model ----------------
  int m_car, m_refq, m_level, m_full;
  bit m_rise, m_alt, m_halfq;
  bit m_cur[4];
  int m_left[4];
  bit m_hi[4], m_lo[4];

  function automatic int exp_mag(input int r, input int car);
    int a;
    a = (r < 0) ? -r : r;
    if (a <= P) return (a > car) ? 1 : 0;
    return (a - P > car) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_car = 0; m_rise = 1; m_refq = 0; m_alt = 0; m_halfq = 0;
      m_level = 0; m_full = 0;
      for (int k = 0; k < 4; k++) begin
        m_cur[k] = 0; m_left[k] = 0; m_hi[k] = 0; m_lo[k] = 0;
      end
    end else begin
      int lv; bit pos, half, blank; bit c[4];
      lv   = exp_mag(m_refq, m_car);
      pos  = m_refq > 0;
      half = (lv == 1);
      c[0] = pos; c[1] = !pos;
      c[2] = (lv == 2) || (half && !m_alt);
      c[3] = (lv == 2) || (half && m_alt);
      blank = (c[0] != m_cur[0]) || (m_left[0] != 0);
      for (int k = 0; k < 4; k++) begin
        if (c[k] != m_cur[k]) begin
          m_cur[k] = c[k]; m_left[k] = int'(dead_r); m_hi[k] = 0; m_lo[k] = 0;
        end else if (m_left[k] > 0) begin
          m_left[k]--; m_hi[k] = 0; m_lo[k] = 0;
        end else begin
          m_hi[k] = m_cur[k] && !(k >= 2 && blank);
          m_lo[k] = !m_cur[k] && !(k >= 2 && blank);
        end
      end
      m_level = pos ? lv : -lv;
      m_full  = (((m_refq < 0) ? -m_refq : m_refq) > P);
      if (m_halfq && !half) m_alt = !m_alt;
      m_halfq = half;
      if (m_car == 0 || m_car == P) m_refq = int'(ref_r);
      if (m_rise) begin
        m_car++; if (m_car == P) m_rise = 0;
      end else begin
        m_car--; if (m_car == 0) m_rise = 1;
      end
    end
  end

  task automatic report(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int eg;
      eg = 0;
      for (int k = 0; k < 4; k++) eg |= (int'(m_hi[k]) << (2*k)) | (int'(m_lo[k]) << (2*k+1));
      report(int'(level) == m_level, m_full ? "R4" : "R5", int'(level), m_level);
      report(int'(gate[3:0]) == (eg & 15), "R2", int'(gate[3:0]), eg & 15);
      report(int'(gate[7:4]) == (eg >> 4), "R6", int'(gate[7:4]), eg >> 4);
      report(!((gate[0] & gate[1]) | (gate[2] & gate[3]) | (gate[4] & gate[5]) | (gate[6] & gate[7])),
             "R3", int'(gate), 0);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R6: successive single-switch intervals alternate
  task automatic alt_scan(input int n);
    bit prev_single = 0; int last = -1;
    for (int i = 0; i < n; i++) begin
      bit single;
      @(negedge clk);
      single = gate[4] ^ gate[6];
      if (single && !prev_single) begin
        if (last >= 0) report(int'(gate[4]) != last, "R6", int'(gate[4]), 1 - last);
        last = int'(gate[4]);
      end
      prev_single = single;
    end
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    // R10: reset state
    cycles(3);
    report(gate == 8'h00, "R10", int'(gate), 0);
    report(level == 3'sd0, "R10", int'(level), 0);
    @(negedge clk); rst_n = 1'b1;

    // R6: half band alternation, first interval uses upper switch
    ref_r = RW'(P/2);
    begin
      int first; first = -1;
      for (int i = 0; i < 4*P && first < 0; i++) begin
        @(negedge clk);
        if (gate[4] ^ gate[6]) first = int'(gate[4]);
      end
      report(first == 1, "R6", first, 1);
    end
    alt_scan(8*P);
    ref_r = RW'(P + P/2);
    cycles(2*P);
    alt_scan(8*P);

    // R7: encoding of a negative full level
    ref_r = -RW'(2*P + 1);
    cycles(3*P);
    report(level == 3'b110, "R7", int'(level), -2);

    // R1: change mid half-period has no effect until the next turn
    ref_r = RW'(P/2);
    cycles(3*P);
    while (!(m_rise && m_car == P/2)) @(negedge clk);
    ref_r = -RW'(2*P);
    for (int i = 0; i < P/2 - 2; i++) begin
      @(negedge clk);
      report(level >= 3'sd0, "R1", int'(level), 0);
    end

    // R8 / R9: dead gap at polarity reversal
    dead_r = DW'(5);
    ref_r = RW'(P/2);
    cycles(3*P);
    ref_r = -RW'(P/2);
    begin
      int gap; bit dc_on; gap = 0; dc_on = 0;
      for (int i = 0; i < 4*P && !gate[0] == 0; i++) @(negedge clk);
      while (gate[1:0] == 2'b00 && gap < 4*P) begin
        gap++; dc_on |= |gate[7:4];
        @(negedge clk);
      end
      report(gap == 6, "R8", gap, 6);
      report(!dc_on, "R9", int'(dc_on), 0);
      report(gate[1:0] == 2'b10, "R2", int'(gate[1:0]), 2);
    end

    // directed corners: zero, band edges, extremes
    dead_r = '0;
    ref_r = '0;            cycles(3*P);
    ref_r = RW'(P);        cycles(3*P);
    ref_r = RW'(P + 1);    cycles(3*P);
    ref_r = -RW'(P);       cycles(3*P);
    ref_r = {1'b0, {(RW-1){1'b1}}}; cycles(3*P);
    ref_r = {1'b1, {(RW-1){1'b0}}}; cycles(3*P);

    // constrained random phase
    for (int s = 0; s < 80; s++) begin
      int r;
      dead_r = DW'($urandom_range(0, 3));
      r = int'($urandom_range(0, 6*P)) - 3*P;
      if ($urandom_range(0, 9) == 0) r = ($urandom_range(0, 1) == 1) ? 2047 : -2048;
      ref_r = RW'(r);
      cycles(int'($urandom_range(1, 5*P)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule